// File: doc/BRIEF.md
# Reset Source Sequencer

This block merges every source of system reset into one internal reset. The sources are a power-on indication, the level of a shared open-drain reset pin, a watchdog timeout request and a clock-failure request. Each reset sequence pulls the pin low for a fixed number of cycles and then lets it go. After a short settling delay the block samples the pin level again. If the pin is still low, the reset came from outside. If it is high, the reset was internal, and the block looks at the latched fault flags to find the cause.

The result is a 16-bit vector address, presented on the cycle the sequence ends, together with a one-cycle pulse that tells the core to set its stop-disable, non-maskable-mask and maskable-mask condition bits. Watchdog and clock-failure requests are held from the cycle they arrive until a vector has been issued. The clock-failure flag is honoured only while its enable input is high. A power-on event first waits a long, fixed stabilisation interval. It then runs the same pin pulse and sampling steps, so external logic sees every reset on the pin.

Top module: `rstsrc_sequencer`

## Requirements
- R1: While running (no reset in progress), a low level on `pin_level_i` at a clock edge starts a sequence. On the next cycle `pin_pull_o` and `sys_rst_o` are both high.
- R2: `pin_pull_o` stays high for exactly PULL_CYCLES (default 4) consecutive cycles per sequence. `sys_rst_o` is high throughout.
- R3: After the pull is released, the pin is sampled at the end of the SAMPLE_DELAY-th cycle (default 2). `exit_o` follows in the next cycle. If the sample is low, the reset is external and `vec_addr_o` becomes 16'hFFFE, whatever fault flags are pending.
- R4: If the sample is high and a clock-failure request is pending, `vec_addr_o` becomes 16'hFFFC. This holds even when a watchdog request is also pending.
- R5: If the sample is high, a watchdog request is pending and no clock-failure request is pending, `vec_addr_o` becomes 16'hFFFA. With nothing pending it becomes 16'hFFFE.
- R6: While `por_i` is high, and for POR_CYCLES cycles after it falls, `sys_rst_o` is high and `pin_pull_o` is low. The reset values are `vec_addr_o` = 16'hFFFE, `exit_o` = 0 and `ccr_set_o` = 0. The pull and sample sequence then follows.
- R7: `cmon_fail_i` has no effect while `cmon_en_i` is low. It starts no reset, and it does not make a later sequence pick 16'hFFFC.
- R8: A one-cycle pulse on `wdog_req_i` or on an enabled `cmon_fail_i` is latched at the next edge, and `pin_pull_o` rises one cycle after that. All latched requests are cleared on the exit cycle, so no second sequence follows.
- R9: `exit_o` is high for exactly one cycle per sequence, with `sys_rst_o` still high. `ccr_set_o` is 3'b111 (bit 2 stop-disable, bit 1 non-maskable mask, bit 0 maskable mask) on that cycle and 3'b000 otherwise. On the next cycle `sys_rst_o` is low, and `vec_addr_o` holds its value until the next sample.
- R10: A request latched after a sequence has started, but before its sample, is used by that sequence's decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (E-clock domain) |
| por_i | input | 1 | Power-on indication, active high, synchronous |
| pin_level_i | input | 1 | Sampled level of the shared reset pin, 1 = high |
| wdog_req_i | input | 1 | Watchdog timeout request |
| cmon_fail_i | input | 1 | Clock-failure request from the clock detector |
| cmon_en_i | input | 1 | Enable for clock-failure resets |
| pin_pull_o | output | 1 | Pull-down enable for the open-drain reset pin |
| sys_rst_o | output | 1 | Internal system reset, active high |
| vec_addr_o | output | 16 | Reset vector address to fetch |
| exit_o | output | 1 | One-cycle pulse marking the end of a sequence |
| ccr_set_o | output | 3 | Condition bits to set on exit: {stop-disable, non-maskable mask, maskable mask} |

## Verification
The bench builds the block with POR_CYCLES set to 64 and keeps the default pull width of 4 and sample delay of 2. The short power-on interval lets the whole stabilisation window be counted cycle by cycle. The pull width and sample delay are measured exactly as they would be in silicon. The pin is modelled as a wired-AND of the block's pull-down and a push button. This reaches the corner cases where the button is held past the sample and where it is released during the pull. It also reaches a watchdog request that arrives mid-sequence and a clock failure that competes with a watchdog timeout.

// File: rtl/rstsrc_pkg.sv
package rstsrc_pkg;

    typedef enum logic [2:0] {
        ST_POR,
        ST_PULL,
        ST_WAIT,
        ST_EXIT,
        ST_RUN
    } seq_state_e;

    typedef enum logic [1:0] {
        SRC_NORMAL,
        SRC_CMON,
        SRC_WDOG
    } rst_src_e;

    typedef struct packed {
        logic cmon;
        logic wdog;
    } pend_t;

    typedef struct packed {
        logic s;
        logic x;
        logic i;
    } ccr_mask_t;

    localparam logic [15:0] VEC_NORMAL = 16'hFFFE;
    localparam logic [15:0] VEC_CMON   = 16'hFFFC;
    localparam logic [15:0] VEC_WDOG   = 16'hFFFA;

    // Low pin at sample time means the reset came from outside.
    function automatic rst_src_e resolve_src(input logic pin_high, input pend_t p);
        rst_src_e r;
        if (!pin_high)   r = SRC_NORMAL;
        else if (p.cmon) r = SRC_CMON;
        else if (p.wdog) r = SRC_WDOG;
        else             r = SRC_NORMAL;
        return r;
    endfunction

    function automatic logic [15:0] src_vector(input rst_src_e s);
        logic [15:0] v;
        case (s)
            SRC_CMON: v = VEC_CMON;
            SRC_WDOG: v = VEC_WDOG;
            default:  v = VEC_NORMAL;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/rstsrc_pending.sv
module rstsrc_pending
    import rstsrc_pkg::*;
(
    input  logic  clk,
    input  logic  por_i,
    input  logic  wdog_req_i,
    input  logic  cmon_fail_i,
    input  logic  cmon_en_i,
    input  logic  clear_i,
    output pend_t pend_o
);

    pend_t pend_q;

    // A request in the clearing cycle itself is kept: set wins.
    always_ff @(posedge clk) begin
        if (por_i) begin
            pend_q <= '0;
        end else begin
            pend_q.wdog <= (pend_q.wdog & ~clear_i) | wdog_req_i;
            pend_q.cmon <= cmon_en_i ? ((pend_q.cmon & ~clear_i) | cmon_fail_i) : 1'b0;
        end
    end

    assign pend_o = pend_q;

    p_cmon_gate_r7: assert property (@(posedge clk) disable iff (por_i)
        !cmon_en_i |=> !pend_o.cmon)
        else $error("clock-failure flag held while disabled");

    p_wdog_latch_r8: assert property (@(posedge clk) disable iff (por_i)
        wdog_req_i |=> pend_o.wdog)
        else $error("watchdog request not latched");

endmodule

// File: rtl/rstsrc_fsm.sv
module rstsrc_fsm
    import rstsrc_pkg::*;
#(
    parameter int POR_CYCLES   = 4064,
    parameter int PULL_CYCLES  = 4,
    parameter int SAMPLE_DELAY = 2
) (
    input  logic  clk,
    input  logic  por_i,
    input  logic  pin_level_i,
    input  pend_t pend_i,
    output logic  pull_o,
    output logic  in_reset_o,
    output logic  sample_o,
    output logic  exit_o
);

    localparam int MAXC = (POR_CYCLES > PULL_CYCLES)
        ? ((POR_CYCLES > SAMPLE_DELAY) ? POR_CYCLES : SAMPLE_DELAY)
        : ((PULL_CYCLES > SAMPLE_DELAY) ? PULL_CYCLES : SAMPLE_DELAY);
    localparam int CW = $clog2(MAXC + 1);

    seq_state_e      state_q;
    logic [CW-1:0]   cnt_q;
    logic            start_req;

    assign start_req = !pin_level_i || pend_i.cmon || pend_i.wdog;

    always_ff @(posedge clk) begin
        if (por_i) begin
            state_q <= ST_POR;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_POR: begin
                    if (cnt_q == CW'(POR_CYCLES - 1)) begin
                        state_q <= ST_PULL;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_PULL: begin
                    if (cnt_q == CW'(PULL_CYCLES - 1)) begin
                        state_q <= ST_WAIT;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (cnt_q == CW'(SAMPLE_DELAY - 1)) begin
                        state_q <= ST_EXIT;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_EXIT: begin
                    state_q <= ST_RUN;
                    cnt_q   <= '0;
                end
                default: begin
                    if (start_req) begin
                        state_q <= ST_PULL;
                        cnt_q   <= '0;
                    end
                end
            endcase
        end
    end

    assign pull_o     = (state_q == ST_PULL);
    assign in_reset_o = (state_q != ST_RUN);
    assign sample_o   = (state_q == ST_WAIT) && (cnt_q == CW'(SAMPLE_DELAY - 1));
    assign exit_o     = (state_q == ST_EXIT);

    // Run-length counter that supports the pull-width check.
    logic [CW:0] pull_len_q;
    always_ff @(posedge clk) begin
        if (por_i)       pull_len_q <= '0;
        else if (pull_o) pull_len_q <= pull_len_q + 1'b1;
        else             pull_len_q <= '0;
    end

    p_pull_width_r2: assert property (@(posedge clk) disable iff (por_i)
        $fell(pull_o) |-> (pull_len_q == (CW+1)'(PULL_CYCLES)))
        else $error("pull pulse width wrong");

    p_run_entry_r1: assert property (@(posedge clk) disable iff (por_i)
        (!in_reset_o && !pin_level_i) |=> (pull_o && in_reset_o))
        else $error("low pin did not start a sequence");

    p_sample_then_exit_r3: assert property (@(posedge clk) disable iff (por_i)
        sample_o |=> (exit_o && !pull_o))
        else $error("exit did not follow sample");

    p_exit_single_r9: assert property (@(posedge clk) disable iff (por_i)
        exit_o |=> (!exit_o && !in_reset_o))
        else $error("exit not a single cycle");

endmodule

// File: rtl/rstsrc_vector.sv
module rstsrc_vector
    import rstsrc_pkg::*;
(
    input  logic        clk,
    input  logic        por_i,
    input  logic        sample_i,
    input  logic        exit_i,
    input  logic        pin_level_i,
    input  pend_t       pend_i,
    output logic [15:0] vec_o,
    output ccr_mask_t   mask_o
);

    logic [15:0] vec_q;

    always_ff @(posedge clk) begin
        if (por_i)         vec_q <= VEC_NORMAL;
        else if (sample_i) vec_q <= src_vector(resolve_src(pin_level_i, pend_i));
    end

    assign vec_o  = vec_q;
    assign mask_o = exit_i ? '{s: 1'b1, x: 1'b1, i: 1'b1} : '0;

    p_vec_legal_r5: assert property (@(posedge clk) disable iff (por_i)
        (vec_o == VEC_NORMAL) || (vec_o == VEC_CMON) || (vec_o == VEC_WDOG))
        else $error("illegal vector");

    p_ext_wins_r3: assert property (@(posedge clk) disable iff (por_i)
        (sample_i && !pin_level_i) |=> (vec_o == VEC_NORMAL))
        else $error("external reset not given normal vector");

    p_cmon_first_r4: assert property (@(posedge clk) disable iff (por_i)
        (sample_i && pin_level_i && pend_i.cmon) |=> (vec_o == VEC_CMON))
        else $error("clock-failure not preferred");

    p_vec_hold_r9: assert property (@(posedge clk) disable iff (por_i)
        !$stable(vec_o) |-> $past(sample_i))
        else $error("vector moved outside a sample");

endmodule

// File: rtl/rstsrc_sequencer.sv
module rstsrc_sequencer
    import rstsrc_pkg::*;
#(
    parameter int POR_CYCLES   = 4064,
    parameter int PULL_CYCLES  = 4,
    parameter int SAMPLE_DELAY = 2
) (
    input  logic        clk,
    input  logic        por_i,
    input  logic        pin_level_i,
    input  logic        wdog_req_i,
    input  logic        cmon_fail_i,
    input  logic        cmon_en_i,
    output logic        pin_pull_o,
    output logic        sys_rst_o,
    output logic [15:0] vec_addr_o,
    output logic        exit_o,
    output logic [2:0]  ccr_set_o
);

    pend_t     pend;
    logic      sample;
    logic      exit_w;
    ccr_mask_t mask;

    rstsrc_pending u_pending (
        .clk         (clk),
        .por_i       (por_i),
        .wdog_req_i  (wdog_req_i),
        .cmon_fail_i (cmon_fail_i),
        .cmon_en_i   (cmon_en_i),
        .clear_i     (exit_w),
        .pend_o      (pend)
    );

    rstsrc_fsm #(
        .POR_CYCLES   (POR_CYCLES),
        .PULL_CYCLES  (PULL_CYCLES),
        .SAMPLE_DELAY (SAMPLE_DELAY)
    ) u_fsm (
        .clk         (clk),
        .por_i       (por_i),
        .pin_level_i (pin_level_i),
        .pend_i      (pend),
        .pull_o      (pin_pull_o),
        .in_reset_o  (sys_rst_o),
        .sample_o    (sample),
        .exit_o      (exit_w)
    );

    rstsrc_vector u_vector (
        .clk         (clk),
        .por_i       (por_i),
        .sample_i    (sample),
        .exit_i      (exit_w),
        .pin_level_i (pin_level_i),
        .pend_i      (pend),
        .vec_o       (vec_addr_o),
        .mask_o      (mask)
    );

    assign exit_o    = exit_w;
    assign ccr_set_o = mask;

    p_pull_in_reset_r6: assert property (@(posedge clk)
        por_i |=> (sys_rst_o && !pin_pull_o))
        else $error("power-on did not hold reset");

endmodule

// File: tb/rstsrc_sequencer_test.sv
module rstsrc_sequencer_test;

    localparam int POR_N  = 64;
    localparam int PULL_N = 4;
    localparam int SAMP_N = 2;

    logic        clk = 1'b0;
    logic        por = 1'b1;
    logic        btn = 1'b0;
    logic        wdog = 1'b0;
    logic        cfail = 1'b0;
    logic        cen = 1'b1;
    logic        pull, srst, ex;
    logic [15:0] vec;
    logic [2:0]  ccr;
    logic        pin;

    int total = 0;
    int bad = 0;
    bit wd_fired = 1'b0;

    always #2 clk = ~clk;

    assign pin = ~(pull | btn);

    rstsrc_sequencer #(.POR_CYCLES(POR_N)) uut (
        .clk (clk), .por_i (por), .pin_level_i (pin),
        .wdog_req_i (wdog), .cmon_fail_i (cfail), .cmon_en_i (cen),
        .pin_pull_o (pull), .sys_rst_o (srst), .vec_addr_o (vec),
        .exit_o (ex), .ccr_set_o (ccr)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Starts at a negedge where the pull is visible; pre = pull cycles already seen.
    task automatic observe(input logic [15:0] exp_vec, input string req, input int pre);
        int w = pre;
        int g = 0;
        int rst_low = 0;
        while (pull && w < 50) begin
            if (!srst) rst_low++;
            w++;
            @(negedge clk);
        end
        chk("R2", "pull width", w, PULL_N);
        chk("R2", "reset low during pull", rst_low, 0);
        while (!ex && g < 50) begin
            g++;
            @(negedge clk);
        end
        chk("R3", "release-to-exit delay", g, SAMP_N);
        chk(req, "vector", int'(vec), int'(exp_vec));
        chk("R9", "ccr bits on exit", int'(ccr), 7);
        chk("R9", "reset held on exit", int'(srst), 1);
        btn = 1'b0;
        @(negedge clk);
        chk("R9", "exit single", int'(ex), 0);
        chk("R9", "reset dropped", int'(srst), 0);
        chk("R9", "ccr cleared", int'(ccr), 0);
        chk("R9", "vector held", int'(vec), int'(exp_vec));
    endtask

    task automatic quiet(input int n, input string req);
        int hits = 0;
        repeat (n) begin
            @(negedge clk);
            if (srst || pull) hits++;
        end
        chk(req, "no further reset", hits, 0);
    endtask

    task automatic t_por();
        int n = 0;
        int rst_low = 0;
        repeat (3) @(negedge clk);
        chk("R6", "reset in por", int'(srst), 1);
        chk("R6", "no pull in por", int'(pull), 0);
        chk("R6", "exit in por", int'(ex), 0);
        chk("R6", "vector reset value", int'(vec), 16'hFFFE);
        chk("R6", "ccr reset value", int'(ccr), 0);
        por = 1'b0;
        while (!pull && n < POR_N + 20) begin
            @(negedge clk);
            if (!srst) rst_low++;
            n++;
        end
        chk("R6", "stabilisation length", n, POR_N);
        chk("R6", "reset low in stabilisation", rst_low, 0);
        observe(16'hFFFE, "R6", 0);
        quiet(8, "R8");
    endtask

    task automatic t_ext_long();
        btn = 1'b1;
        @(negedge clk);
        chk("R1", "pull after low pin", int'(pull), 1);
        chk("R1", "reset after low pin", int'(srst), 1);
        observe(16'hFFFE, "R3", 0);
        quiet(8, "R8");
    endtask

    task automatic t_ext_wins();
        btn = 1'b1;
        wdog = 1'b1;
        @(negedge clk);
        wdog = 1'b0;
        chk("R1", "pull with pin and watchdog", int'(pull), 1);
        observe(16'hFFFE, "R3", 0);
        quiet(8, "R8");
    endtask

    task automatic t_short_btn();
        btn = 1'b1;
        @(negedge clk);
        btn = 1'b0;
        observe(16'hFFFE, "R5", 0);
        quiet(8, "R8");
    endtask

    task automatic t_wdog();
        wdog = 1'b1;
        @(negedge clk);
        wdog = 1'b0;
        chk("R8", "no pull while latching", int'(pull), 0);
        @(negedge clk);
        chk("R8", "pull after latch", int'(pull), 1);
        observe(16'hFFFA, "R5", 0);
        quiet(8, "R8");
    endtask

    task automatic t_cmon_first();
        cen = 1'b1;
        wdog = 1'b1;
        cfail = 1'b1;
        @(negedge clk);
        wdog = 1'b0;
        cfail = 1'b0;
        @(negedge clk);
        chk("R8", "pull after clock failure", int'(pull), 1);
        observe(16'hFFFC, "R4", 0);
        quiet(8, "R8");
    endtask

    task automatic t_cmon_off();
        cen = 1'b0;
        cfail = 1'b1;
        @(negedge clk);
        cfail = 1'b0;
        quiet(10, "R7");
        wdog = 1'b1;
        @(negedge clk);
        wdog = 1'b0;
        @(negedge clk);
        observe(16'hFFFA, "R7", 0);
        cen = 1'b1;
        quiet(4, "R8");
    endtask

    task automatic t_late_req();
        btn = 1'b1;
        @(negedge clk);
        btn = 1'b0;
        wdog = 1'b1;
        @(negedge clk);
        wdog = 1'b0;
        observe(16'hFFFA, "R10", 1);
        quiet(8, "R8");
    endtask

    initial begin
        fork
            begin
                t_por();
                t_ext_long();
                t_ext_wins();
                t_short_btn();
                t_wdog();
                t_cmon_first();
                t_cmon_off();
                t_late_req();
            end
            begin
                repeat (100000) @(posedge clk);
                wd_fired = 1'b1;
            end
        join_any
        disable fork;
        if (wd_fired) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=expired expected=done");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule